// File: doc/BRIEF.md
# AAL1 Receive Cell Filter and Sequence Checker

This block sits on the receive path of a circuit-emulation adaptation layer. Each incoming cell arrives as one header byte followed by 47 payload bytes. The cell's path and circuit identifiers are presented alongside the header byte. A small associative connection table maps the identifier pair to a local channel number. Cells that belong to no configured connection are swallowed and reported.

For a matched cell, the block decodes the one-byte adaptation header. The header carries a 3-bit sequence count, protected by a 3-bit cyclic check and an even-parity bit. Single-bit errors are repaired. Double errors cause the cell to be thrown away.

The repaired count is compared with the count expected for that channel. A mismatch is flagged, and the channel resynchronises to the count it received. Accepted payload bytes are written one per cycle into the channel's slice of a shared receive buffer. A one-cycle flag pulse on the last byte tells the downstream playout logic that the channel's payload is ready.

Top module: `aal1_rx_filter`

## Requirements
- R1: A header byte with `cell_vpi`/`cell_vci` equal to a valid table entry is mapped to that entry's channel. When several valid entries match, the lowest entry index wins. An entry is written by `map_we`, with `map_valid` choosing whether it is valid.
- R2: A header byte that matches no valid entry gives `drop_pulse` one cycle later and no buffer writes. The block still consumes the next 47 valid bytes as that cell's payload.
- R3: The header byte holds the convergence indication in bit 7 and the sequence count in bits 6:4. Bits 3:1 hold the remainder of bits 7:4 followed by three zeros, divided by x^3+x+1. Bit 0 makes the byte's parity even. A clean header is accepted with no header pulse.
- R4: A header whose parity fails is treated as having a single-bit error. It is corrected and accepted, and `hdr_fixed_pulse` rises one cycle after the header byte. The corrected count is the one used for sequence checking.
- R5: A header with a nonzero remainder and passing parity raises `hdr_bad_pulse` one cycle later. Its payload is not written, and the channel's expected count is left unchanged.
- R6: After reset, or after a valid table write naming a channel, the first accepted cell on that channel is taken with no sequence error. The expected count becomes its count plus one, modulo 8.
- R7: A later accepted cell whose count differs from the expected count raises `seq_err_pulse`, with `seq_err_chan` set, one cycle after the header byte. Its payload is still written, and the expected count becomes the received count plus one.
- R8: Payload byte k (0 to 46) of an accepted cell on channel c is written at address c*47+k, one cycle after it is presented. `flag_set` with `flag_chan`=c accompanies the write of byte 46.
- R9: When no cell is in progress, valid bytes without `cell_sop` are ignored. While a cell is in progress, `cell_sop` is ignored, and cycles with `cell_valid` low neither advance nor write.
- R10: After reset all outputs are zero and the table is empty, so every cell is dropped until entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Connection table write strobe |
| map_idx | input | IDX_W | Table entry written |
| map_valid | input | 1 | Entry valid; also re-arms the channel's first-cell rule |
| map_vpi | input | VPI_W | Path identifier for the entry |
| map_vci | input | VCI_W | Circuit identifier for the entry |
| map_chan | input | CH_W | Channel the entry maps to |
| cell_valid | input | 1 | Byte strobe |
| cell_sop | input | 1 | Marks the header byte |
| cell_byte | input | 8 | Header or payload byte |
| cell_vpi | input | VPI_W | Path identifier, sampled with the header byte |
| cell_vci | input | VCI_W | Circuit identifier, sampled with the header byte |
| buf_we | output | 1 | Receive buffer write |
| buf_addr | output | ADDR_W | Receive buffer address |
| buf_data | output | 8 | Receive buffer data |
| flag_set | output | 1 | Payload-ready pulse |
| flag_chan | output | CH_W | Channel whose payload is ready |
| drop_pulse | output | 1 | Unmatched cell dropped |
| hdr_fixed_pulse | output | 1 | Header corrected |
| hdr_bad_pulse | output | 1 | Header uncorrectable, cell discarded |
| seq_err_pulse | output | 1 | Sequence count mismatch |
| seq_err_chan | output | CH_W | Channel of the mismatch |

## Verification
The assertions check the following on every cycle:
- buffer addresses stay within the buffer;
- writes inside one cell step by one address;
- the ready flag lands on the last slot of its channel;
- drop, bad-header and flag pulses never coincide;
- a dropped or discarded cell produces no write.

Only the bench's scenarios can show the rest:
- whether the correct channel was chosen when table entries overlap;
- whether a corrected count, rather than the raw one, was used;
- that a discarded header left the expected count untouched;
- that re-enabling a channel suppresses the next mismatch.

The bench shows these by comparing against a reference that decodes headers by nearest-codeword search.

// File: rtl/aal1_rx_filter.sv
`timescale 1ns/1ps
module aal1_rx_filter #(
  parameter int NCHAN = 4,
  parameter int LUT_N = 8,
  parameter int VPI_W = 8,
  parameter int VCI_W = 16,
  parameter int PAY   = 47,
  localparam int CH_W   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int IDX_W  = (LUT_N > 1) ? $clog2(LUT_N) : 1,
  localparam int CNT_W  = $clog2(PAY),
  localparam int ADDR_W = $clog2(NCHAN * PAY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_we,
  input  logic [IDX_W-1:0]  map_idx,
  input  logic              map_valid,
  input  logic [VPI_W-1:0]  map_vpi,
  input  logic [VCI_W-1:0]  map_vci,
  input  logic [CH_W-1:0]   map_chan,
  input  logic              cell_valid,
  input  logic              cell_sop,
  input  logic [7:0]        cell_byte,
  input  logic [VPI_W-1:0]  cell_vpi,
  input  logic [VCI_W-1:0]  cell_vci,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic              flag_set,
  output logic [CH_W-1:0]   flag_chan,
  output logic              drop_pulse,
  output logic              hdr_fixed_pulse,
  output logic              hdr_bad_pulse,
  output logic              seq_err_pulse,
  output logic [CH_W-1:0]   seq_err_chan
);

  logic             tbl_v   [LUT_N];
  logic [VPI_W-1:0] tbl_vpi [LUT_N];
  logic [VCI_W-1:0] tbl_vci [LUT_N];
  logic [CH_W-1:0]  tbl_ch  [LUT_N];

  logic             synced  [NCHAN];
  logic [2:0]       expc    [NCHAN];

  logic             busy, act;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  cur_ch;

  function automatic logic [2:0] rem7(input logic [6:0] v);
    logic [6:0] r;
    r = v;
    for (int i = 6; i >= 3; i--)
      if (r[i]) r = r ^ (7'b0001011 << (i - 3));
    return r[2:0];
  endfunction

  logic            hit;
  logic [CH_W-1:0] hit_ch;
  always_comb begin
    hit    = 1'b0;
    hit_ch = '0;
    for (int i = LUT_N - 1; i >= 0; i--)
      if (tbl_v[i] && tbl_vpi[i] == cell_vpi && tbl_vci[i] == cell_vci) begin
        hit    = 1'b1;
        hit_ch = tbl_ch[i];
      end
  end

  wire [2:0] syn     = rem7(cell_byte[7:1]);
  wire       par_bad = ^cell_byte;

  logic [2:0] sc_flip;
  always_comb begin
    sc_flip = '0;
    for (int k = 3; k <= 5; k++)
      if (syn != 3'd0 && rem7(7'(1) << k) == syn) sc_flip[k-3] = 1'b1;
  end

  wire [2:0] sc       = cell_byte[6:4] ^ sc_flip;
  wire       hdr_ok   = (syn == 3'd0) || par_bad;
  wire       start    = cell_valid && cell_sop && !busy;
  wire       accept   = start && hit && hdr_ok;
  wire       mismatch = synced[hit_ch] && (expc[hit_ch] != sc);
  wire       pay_in   = busy && cell_valid;
  wire       last     = (cnt == CNT_W'(PAY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LUT_N; i++) begin
        tbl_v[i]   <= 1'b0;
        tbl_vpi[i] <= '0;
        tbl_vci[i] <= '0;
        tbl_ch[i]  <= '0;
      end
    end else if (map_we) begin
      tbl_v[map_idx]   <= map_valid;
      tbl_vpi[map_idx] <= map_vpi;
      tbl_vci[map_idx] <= map_vci;
      tbl_ch[map_idx]  <= map_chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHAN; c++) begin
        synced[c] <= 1'b0;
        expc[c]   <= '0;
      end
    end else begin
      for (int c = 0; c < NCHAN; c++) begin
        if (map_we && map_valid && map_chan == CH_W'(c)) begin
          synced[c] <= 1'b0;
        end else if (accept && hit_ch == CH_W'(c)) begin
          synced[c] <= 1'b1;
          expc[c]   <= sc + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      act    <= 1'b0;
      cnt    <= '0;
      cur_ch <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      act    <= accept;
      cnt    <= '0;
      cur_ch <= hit_ch;
    end else if (pay_in) begin
      cnt <= cnt + CNT_W'(1);
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_we          <= 1'b0;
      buf_addr        <= '0;
      buf_data        <= '0;
      flag_set        <= 1'b0;
      flag_chan       <= '0;
      drop_pulse      <= 1'b0;
      hdr_fixed_pulse <= 1'b0;
      hdr_bad_pulse   <= 1'b0;
      seq_err_pulse   <= 1'b0;
      seq_err_chan    <= '0;
    end else begin
      buf_we          <= pay_in && act;
      flag_set        <= pay_in && act && last;
      flag_chan       <= (pay_in && act && last) ? cur_ch : '0;
      if (pay_in && act) begin
        buf_addr <= ADDR_W'(cur_ch) * ADDR_W'(PAY) + ADDR_W'(cnt);
        buf_data <= cell_byte;
      end
      drop_pulse      <= start && !hit;
      hdr_bad_pulse   <= start && hit && !hdr_ok;
      hdr_fixed_pulse <= accept && par_bad;
      seq_err_pulse   <= accept && mismatch;
      seq_err_chan    <= (accept && mismatch) ? hit_ch : '0;
    end
  end

endmodule

// File: rtl/aal1_rx_filter_chk.sv
`timescale 1ns/1ps
module aal1_rx_filter_chk #(
  parameter int NCHAN = 4,
  parameter int PAY   = 47,
  localparam int CH_W   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int ADDR_W = $clog2(NCHAN * PAY)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              flag_set,
  input logic [CH_W-1:0]   flag_chan,
  input logic              drop_pulse,
  input logic              hdr_fixed_pulse,
  input logic              hdr_bad_pulse,
  input logic              seq_err_pulse
);

  assert_addr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (int'(buf_addr) < NCHAN * PAY));

  assert_flag_on_last_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> buf_we && buf_addr == ADDR_W'(flag_chan) * ADDR_W'(PAY) + ADDR_W'(PAY - 1));

  assert_writes_sequential_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && $past(buf_we) && !$past(flag_set)) |-> buf_addr == $past(buf_addr) + ADDR_W'(1));

  assert_drop_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> !hdr_bad_pulse && !hdr_fixed_pulse && !seq_err_pulse);

  assert_bad_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad_pulse |-> !hdr_fixed_pulse && !seq_err_pulse);

  assert_pulses_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drop_pulse, hdr_bad_pulse, flag_set}));

  assert_no_write_after_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> !buf_we);

  assert_no_write_after_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad_pulse |=> !buf_we);

endmodule

bind aal1_rx_filter aal1_rx_filter_chk #(.NCHAN(NCHAN), .PAY(PAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr),
  .flag_set(flag_set), .flag_chan(flag_chan), .drop_pulse(drop_pulse),
  .hdr_fixed_pulse(hdr_fixed_pulse), .hdr_bad_pulse(hdr_bad_pulse),
  .seq_err_pulse(seq_err_pulse)
);

// File: tb/tb_aal1_rx_filter.sv
`timescale 1ns/1ps
module tb_aal1_rx_filter;
  logic clk = 0, rst_n = 0;
  logic map_we = 0, map_valid = 0;
  logic [2:0] map_idx = 0;
  logic [7:0] map_vpi = 0;
  logic [15:0] map_vci = 0;
  logic [1:0] map_chan = 0;
  logic c_valid = 0, c_sop = 0;
  logic [7:0] c_byte = 0, c_vpi = 0;
  logic [15:0] c_vci = 0;
  logic buf_we, flag_set, drop_pulse, hdr_fixed_pulse, hdr_bad_pulse, seq_err_pulse;
  logic [7:0] buf_addr, buf_data;
  logic [1:0] flag_chan, seq_err_chan;

  aal1_rx_filter dut (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx), .map_valid(map_valid),
    .map_vpi(map_vpi), .map_vci(map_vci), .map_chan(map_chan),
    .cell_valid(c_valid), .cell_sop(c_sop), .cell_byte(c_byte), .cell_vpi(c_vpi), .cell_vci(c_vci),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .flag_set(flag_set),
    .flag_chan(flag_chan), .drop_pulse(drop_pulse), .hdr_fixed_pulse(hdr_fixed_pulse),
    .hdr_bad_pulse(hdr_bad_pulse), .seq_err_pulse(seq_err_pulse), .seq_err_chan(seq_err_chan));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_we = 0, n_flag = 0, n_drop = 0, n_fix = 0, n_bad = 0, n_seq = 0, last_fch = -1, last_sch = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_hdr(input int csi, input int sc);
    logic [3:0] s;
    logic [2:0] r;
    logic [6:0] msg;
    logic fb;
    s = {1'(csi), 3'(sc)};
    msg = {s, 3'b000};
    r = 0;
    for (int i = 6; i >= 0; i--) begin
      fb = r[2];
      r = {r[1:0], msg[i]} ^ (fb ? 3'b011 : 3'b000);
    end
    return {s, r, ^{s, r}};
  endfunction

  function automatic void classify(input logic [7:0] b, output bit ok, output bit fx, output int sc);
    ok = 0; fx = 0; sc = 0;
    for (int s = 0; s < 16; s++) begin
      int d;
      d = $countones(mk_hdr(s / 8, s % 8) ^ b);
      if (d == 0) begin ok = 1; fx = 0; sc = s % 8; end
      else if (d == 1 && !ok) begin ok = 1; fx = 1; sc = s % 8; end
    end
  endfunction

  // reference model
  int m_v[8], m_vpi[8], m_vci[8], m_ch[8], m_sync[4], m_exp[4];
  int m_busy, m_cnt, m_act, m_cur;
  bit e_we, e_flag, e_drop, e_fix, e_bad, e_seq;
  int e_addr, e_data, e_fch, e_sch;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_vpi[i] = 0; m_vci[i] = 0; m_ch[i] = 0; end
      for (int c = 0; c < 4; c++) begin m_sync[c] = 0; m_exp[c] = 0; end
      m_busy = 0; m_cnt = 0; m_act = 0; m_cur = 0;
      {e_we, e_flag, e_drop, e_fix, e_bad, e_seq} = 0;
      e_addr = 0; e_data = 0; e_fch = 0; e_sch = 0;
    end else begin
      {e_we, e_flag, e_drop, e_fix, e_bad, e_seq} = 0;
      e_fch = 0; e_sch = 0;
      if (c_valid && c_sop && !m_busy) begin
        int ch; bit hit, ok, fx; int sc;
        hit = 0; ch = 0; ok = 0;
        for (int i = 0; i < 8; i++)
          if (!hit && m_v[i] != 0 && m_vpi[i] == int'(c_vpi) && m_vci[i] == int'(c_vci)) begin
            hit = 1; ch = m_ch[i];
          end
        if (!hit) e_drop = 1;
        else begin
          classify(c_byte, ok, fx, sc);
          if (!ok) e_bad = 1;
          else begin
            e_fix = fx;
            if (m_sync[ch] != 0 && m_exp[ch] != sc) begin e_seq = 1; e_sch = ch; end
            m_sync[ch] = 1;
            m_exp[ch] = (sc + 1) % 8;
          end
        end
        m_busy = 1; m_cnt = 0; m_act = hit && ok; m_cur = ch;
      end else if (m_busy != 0 && c_valid) begin
        if (m_act != 0) begin
          e_we = 1; e_addr = m_cur * 47 + m_cnt; e_data = c_byte;
          if (m_cnt == 46) begin e_flag = 1; e_fch = m_cur; end
        end
        m_cnt++;
        if (m_cnt == 47) m_busy = 0;
      end
      if (map_we) begin
        m_v[map_idx] = map_valid; m_vpi[map_idx] = map_vpi;
        m_vci[map_idx] = map_vci; m_ch[map_idx] = map_chan;
        if (map_valid) m_sync[map_chan] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(buf_we == e_we, "R8 buf_we", buf_we, e_we);
      if (e_we) begin
        chk(buf_addr == e_addr, "R8 buf_addr", buf_addr, e_addr);
        chk(buf_data == e_data, "R8 buf_data", buf_data, e_data);
      end
      chk(flag_set == e_flag, "R8 flag_set", flag_set, e_flag);
      if (e_flag) chk(flag_chan == e_fch, "R8 flag_chan", flag_chan, e_fch);
      chk(drop_pulse == e_drop, "R2 drop_pulse", drop_pulse, e_drop);
      chk(hdr_fixed_pulse == e_fix, "R4 hdr_fixed_pulse", hdr_fixed_pulse, e_fix);
      chk(hdr_bad_pulse == e_bad, "R5 hdr_bad_pulse", hdr_bad_pulse, e_bad);
      chk(seq_err_pulse == e_seq, "R7 seq_err_pulse", seq_err_pulse, e_seq);
      if (e_seq) chk(seq_err_chan == e_sch, "R7 seq_err_chan", seq_err_chan, e_sch);
      n_we += buf_we; n_flag += flag_set; n_drop += drop_pulse;
      n_fix += hdr_fixed_pulse; n_bad += hdr_bad_pulse; n_seq += seq_err_pulse;
      if (flag_set) last_fch = flag_chan;
      if (seq_err_pulse) last_sch = seq_err_chan;
    end
  end

  task automatic map(input int idx, input int v, input int vpi, input int vci, input int ch);
    @(negedge clk);
    map_we = 1; map_idx = 3'(idx); map_valid = v[0]; map_vpi = 8'(vpi); map_vci = 16'(vci); map_chan = 2'(ch);
    @(negedge clk);
    map_we = 0;
  endtask

  task automatic send_cell(input int vpi, input int vci, input logic [7:0] hdr,
                           input int sop_at = -1, input int gap_at = -1);
    @(negedge clk);
    c_valid = 1; c_sop = 1; c_byte = hdr; c_vpi = 8'(vpi); c_vci = 16'(vci);
    for (int k = 0; k < 47; k++) begin
      if (k == gap_at) begin
        @(negedge clk);
        c_valid = 0; c_sop = 0; c_byte = 8'hEE;
      end
      @(negedge clk);
      c_valid = 1; c_sop = (k == sop_at); c_byte = 8'(k * 5 + hdr);
    end
    @(negedge clk);
    c_valid = 0; c_sop = 0;
    repeat (2) @(negedge clk);
  endtask

  int s_we, s_flag, s_drop, s_fix, s_bad, s_seq;
  task automatic snap();
    s_we = n_we; s_flag = n_flag; s_drop = n_drop; s_fix = n_fix; s_bad = n_bad; s_seq = n_seq;
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] h;
    repeat (3) @(negedge clk);
    chk({buf_we, flag_set, drop_pulse, hdr_fixed_pulse, hdr_bad_pulse, seq_err_pulse} == 0,
        "R10 reset outputs", {buf_we, flag_set, drop_pulse}, 0);
    rst_n = 1;
    @(negedge clk);

    snap(); send_cell(1, 100, mk_hdr(0, 0));
    chk(n_drop - s_drop == 1 && n_we == s_we, "R10 empty table drops", n_drop - s_drop, 1);

    map(0, 1, 1, 100, 1);
    map(1, 1, 2, 200, 2);
    map(3, 1, 1, 100, 3);

    snap(); send_cell(1, 100, mk_hdr(1, 0));
    chk(last_fch == 1, "R1 lowest entry wins", last_fch, 1);
    chk(n_seq == s_seq, "R6 first cell accepted", n_seq - s_seq, 0);
    chk(n_fix == s_fix && n_bad == s_bad, "R3 clean header", n_fix - s_fix + n_bad - s_bad, 0);
    chk(n_we - s_we == 47, "R8 write count", n_we - s_we, 47);

    snap(); send_cell(1, 100, mk_hdr(0, 1));
    chk(n_seq == s_seq, "R3 in-order count", n_seq - s_seq, 0);

    snap(); send_cell(1, 100, mk_hdr(0, 3));
    chk(n_seq - s_seq == 1 && last_sch == 1, "R7 gap flagged", n_seq - s_seq, 1);
    chk(n_we - s_we == 47, "R7 payload kept", n_we - s_we, 47);
    snap(); send_cell(1, 100, mk_hdr(0, 4));
    chk(n_seq == s_seq, "R7 resync", n_seq - s_seq, 0);

    h = mk_hdr(0, 5) ^ 8'h20;
    snap(); send_cell(1, 100, h);
    chk(n_fix - s_fix == 1, "R4 corrected", n_fix - s_fix, 1);
    chk(n_seq == s_seq, "R4 corrected count used", n_seq - s_seq, 0);

    h = mk_hdr(0, 6) ^ 8'h22;
    snap(); send_cell(1, 100, h);
    chk(n_bad - s_bad == 1 && n_we == s_we && n_flag == s_flag, "R5 discarded", n_we - s_we, 0);
    snap(); send_cell(1, 100, mk_hdr(0, 6));
    chk(n_seq == s_seq, "R5 expected count unchanged", n_seq - s_seq, 0);

    h = mk_hdr(1, 7) ^ 8'h01;
    snap(); send_cell(1, 100, h);
    chk(n_fix - s_fix == 1 && n_seq == s_seq, "R4 parity bit error", n_fix - s_fix, 1);

    map(0, 1, 1, 100, 1);
    snap(); send_cell(1, 100, mk_hdr(0, 2));
    chk(n_seq == s_seq, "R6 re-enabled channel", n_seq - s_seq, 0);

    @(negedge clk); c_valid = 1; c_sop = 0; c_byte = 8'h55;
    @(negedge clk); c_valid = 1; c_byte = 8'h56;
    @(negedge clk); c_valid = 0;
    snap(); send_cell(2, 200, mk_hdr(0, 4), 10, 20);
    chk(n_we - s_we == 47 && last_fch == 2, "R9 stray bytes and inner sop", n_we - s_we, 47);

    snap(); send_cell(9, 9, mk_hdr(0, 0), 5);
    send_cell(2, 200, mk_hdr(0, 5));
    chk(n_drop - s_drop == 1 && n_we - s_we == 47, "R2 unmatched cell consumed", n_we - s_we, 47);

    map(1, 0, 2, 200, 2);
    snap(); send_cell(2, 200, mk_hdr(0, 6));
    chk(n_drop - s_drop == 1 && n_we == s_we, "R1 invalidated entry", n_drop - s_drop, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule